// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command layer behind a byte-oriented SPI slave front end for a serial non-volatile byte store. The front end hands it every received byte and tells it when chip select goes high. The engine decodes the opcode, collects the address and data bytes, and streams read data or status back to the front end. It holds a write-enable flag, a busy flag, a byte pointer and the storage array, which is modelled here as a plain register array that block RAM can implement.

Writes are not applied as the bytes arrive. They are collected in a page buffer and committed only when chip select rises cleanly after a whole byte. A self-timed busy period then follows. While that period runs, the buffered bytes are copied into the array, and only status reads are answered. An external protection unit answers two questions: whether the address at `qry_addr` may be written, and whether the status byte may be written. Bytes it refuses are dropped one at a time, and the rest of the page is still written. Array reads prefetch the next byte as soon as the current one is taken, so consecutive output bytes follow each other with no gap.

Top module: `eecmd_engine`

## Requirements
- R1: An opcode is valid only when bits 7..4 are zero. Bit 3 is ignored. Bits 2..0 select the command: 110 sets the write-enable flag, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. The values 000 and 111 are unknown.
- R2: After an unknown opcode, `tx_valid` stays low and every further byte is ignored until `cs_rise`.
- R3: The write-enable flag is clear after reset. A set-enable command sets it and a clear-enable command clears it. It clears again when a busy period ends.
- R4: When idle, the status byte is {protect-enable, 0, 0, 0, block1, block0, write-enable, 0}. While busy, it reads 8'hFF.
- R5: A read or write opcode is followed by a 16-bit address, high byte first, and address bits at or above ADDR_W are ignored. A read streams bytes from that address, adding one to the address per byte taken. After the top address it continues at address 0.
- R6: Data bytes of a write advance only the low log2(PAGE_BYTES) address bits. Bytes beyond one page wrap to the start of the page and replace earlier bytes.
- R7: A write opcode issued while the write-enable flag is clear is ignored and starts no busy period.
- R8: A write commits only if `cs_rise` comes with `cs_aligned` high and at least one complete data byte has been received. Otherwise nothing is written, no busy period starts and the write-enable flag is kept.
- R9: A commit starts a busy period of max(WRITE_CYCLES, PAGE_BYTES) cycles. During that period every opcode except a status read is ignored, including set-enable and array read.
- R10: A data byte whose address `qry_array_ok` reports as protected at the moment it arrives is dropped. Other bytes of the same page are still written.
- R11: A status write requires the write-enable flag and `qry_status_ok`. When it commits, data bits 7, 3 and 2 become protect-enable, block1 and block0, which also drive `cfg_wpen` and `cfg_bp`.
- R12: During an array read, the next byte is valid on `tx_byte` in the second cycle after `tx_take`.
- R13: A final data byte delivered in the same cycle as an aligned `cs_rise` belongs to the committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte received from the serial front end |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| cs_rise | input | 1 | One-cycle strobe: chip select went high |
| cs_aligned | input | 1 | With `cs_rise`: no partial byte was pending |
| tx_take | input | 1 | Front end has started shifting `tx_byte` |
| tx_byte | output | 8 | Next byte to shift out |
| tx_valid | output | 1 | `tx_byte` is valid; when low the output stays undriven |
| qry_addr | output | ADDR_W | Address of the next data byte, sent to the protection unit |
| qry_array_ok | input | 1 | `qry_addr` may be written |
| qry_status_ok | input | 1 | Status byte may be written |
| cfg_wpen | output | 1 | Stored protect-enable bit |
| cfg_bp | output | 2 | Stored block-protect level |

## Verification
Two events can fall in the same cycle: the arrival of the last data byte of a write and the aligned chip-select rise that commits it. The bench drives the final byte with `rx_valid` and `cs_rise` in a single cycle, then reads the page back. The write passes only if that last byte is present in the array and the busy status appeared at once. A second case delivers a byte and then a misaligned rise. Here the bench expects the old array contents, no busy status and a still-set write-enable flag.

// File: rtl/eecmd_pkg.sv
package eecmd_pkg;

  typedef enum logic [3:0] {
    ST_CMD, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA,
    ST_RDSR, ST_WRSR, ST_WRSR_FULL, ST_SKIP
  } eng_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SETWE, OP_CLRWE, OP_RSTAT, OP_WSTAT, OP_READ, OP_WRITE
  } op_e;

  localparam logic [7:0] STAT_BUSY = 8'hFF;

  // bit 3 is a don't-care; the upper nibble must be zero
  function automatic op_e decode_op(input logic [7:0] b);
    op_e r;
    r = OP_NONE;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  r = OP_SETWE;
        3'b100:  r = OP_CLRWE;
        3'b101:  r = OP_RSTAT;
        3'b001:  r = OP_WSTAT;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/eecmd_array.sv
module eecmd_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eecmd_page_buf.sv
module eecmd_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_keep,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_keep
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot  [SLOTS];
  logic [SLOTS-1:0]  keep_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) keep_q <= '0;
    else if (wr_en) keep_q[wr_off] <= wr_keep;
  end

  assign rd_data = slot[rd_off];
  assign rd_keep = keep_q[rd_off];
endmodule

// File: rtl/eecmd_write_timer.sv
module eecmd_write_timer #(
  parameter int BUSY_LEN   = 500000,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  output logic                          busy,
  output logic                          step,
  output logic [$clog2(PAGE_BYTES)-1:0] step_idx,
  output logic                          done
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(BUSY_LEN) + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  assign done     = busy && (cnt == CNT_W'(BUSY_LEN - 1));
  assign step     = busy && (cnt < CNT_W'(PAGE_BYTES));
  assign step_idx = cnt[OFF_W-1:0];

  assert_single_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/eecmd_engine.sv
module eecmd_engine #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              tx_take,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] qry_addr,
  input  logic              qry_array_ok,
  input  logic              qry_status_ok,
  output logic              cfg_wpen,
  output logic [1:0]        cfg_bp
);
  import eecmd_pkg::*;

  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int HI_W     = ADDR_W - 8;
  localparam int BUSY_LEN = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

  eng_state_e        state;
  logic              wel, wpen, is_wr, wr_has, kind_stat;
  logic [1:0]        bp;
  logic [2:0]        stat_pend;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        stat_q, mem_q, pb_data;
  logic              pb_keep, busy, step, done, start;
  logic [OFF_W-1:0]  step_idx;
  logic              data_now, stat_now, take_ok;
  op_e               op;

  assign op       = decode_op(rx_byte);
  assign data_now = rx_valid && (state == ST_WDATA);
  assign stat_now = rx_valid && (state == ST_WRSR);
  assign take_ok  = tx_take && tx_valid && (state == ST_RDATA);
  assign start    = cs_rise && cs_aligned &&
                    (((state == ST_WDATA) && (wr_has || data_now)) ||
                     (state == ST_WRSR_FULL) || stat_now);

  eecmd_write_timer #(.BUSY_LEN(BUSY_LEN), .PAGE_BYTES(PAGE_BYTES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .step(step), .step_idx(step_idx), .done(done)
  );

  eecmd_page_buf #(.DATA_W(8), .OFF_W(OFF_W)) u_page (
    .clk(clk), .rst(rst),
    .clr(rx_valid && (state == ST_ALO)),
    .wr_en(data_now), .wr_off(ptr[OFF_W-1:0]), .wr_data(rx_byte),
    .wr_keep(qry_array_ok),
    .rd_off(step_idx), .rd_data(pb_data), .rd_keep(pb_keep)
  );

  eecmd_array #(.DATA_W(8), .ADDR_W(ADDR_W)) u_array (
    .clk(clk),
    .we(step && !kind_stat && pb_keep),
    .waddr({ptr[ADDR_W-1:OFF_W], step_idx}),
    .wdata(pb_data),
    .raddr(ptr),
    .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CMD;
      wel       <= 1'b0;
      wpen      <= 1'b0;
      bp        <= 2'b00;
      is_wr     <= 1'b0;
      wr_has    <= 1'b0;
      kind_stat <= 1'b0;
      stat_pend <= '0;
      addr_hi   <= '0;
      ptr       <= '0;
      stat_q    <= '0;
      tx_valid  <= 1'b0;
    end else begin
      stat_q   <= busy ? STAT_BUSY : {wpen, 3'b000, bp, wel, 1'b0};
      tx_valid <= !cs_rise && ((state == ST_RDSR) || ((state == ST_RDATA) && !take_ok));
      if (done) begin
        wel <= 1'b0;
        if (kind_stat) begin
          wpen <= stat_pend[2];
          bp   <= stat_pend[1:0];
        end
      end
      if (start) begin
        kind_stat <= (state != ST_WDATA);
        if (stat_now) stat_pend <= {rx_byte[7], rx_byte[3:2]};
      end
      if (take_ok) ptr <= ptr + 1'b1;
      if (cs_rise) begin
        state <= ST_CMD;
      end else if (rx_valid) begin
        unique case (state)
          ST_CMD: begin
            if (busy) begin
              state <= (op == OP_RSTAT) ? ST_RDSR : ST_SKIP;
            end else begin
              unique case (op)
                OP_SETWE: begin wel <= 1'b1; state <= ST_SKIP; end
                OP_CLRWE: begin wel <= 1'b0; state <= ST_SKIP; end
                OP_RSTAT: state <= ST_RDSR;
                OP_WSTAT: state <= (wel && qry_status_ok) ? ST_WRSR : ST_SKIP;
                OP_READ:  begin is_wr <= 1'b0; state <= ST_AHI; end
                OP_WRITE: begin is_wr <= 1'b1; state <= wel ? ST_AHI : ST_SKIP; end
                default:  state <= ST_SKIP;
              endcase
            end
          end
          ST_AHI: begin
            addr_hi <= rx_byte[HI_W-1:0];
            state   <= ST_ALO;
          end
          ST_ALO: begin
            ptr    <= {addr_hi, rx_byte};
            wr_has <= 1'b0;
            state  <= is_wr ? ST_WDATA : ST_RDATA;
          end
          ST_WDATA: begin
            ptr[OFF_W-1:0] <= ptr[OFF_W-1:0] + 1'b1;
            wr_has         <= 1'b1;
          end
          ST_WRSR: begin
            stat_pend <= {rx_byte[7], rx_byte[3:2]};
            state     <= ST_WRSR_FULL;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_byte  = (state == ST_RDSR) ? stat_q : mem_q;
  assign qry_addr = ptr;
  assign cfg_wpen = wpen;
  assign cfg_bp   = bp;

  assert_wel_drop_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !wel);
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |=> !tx_valid);
  assert_page_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (data_now && !cs_rise) |=> (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W])));
  assert_busy_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (stat_q == STAT_BUSY));
endmodule

// File: tb/eecmd_engine_bench.sv
module eecmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WCYC   = 200;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] rx_byte = '0, tx_byte;
  logic rx_valid = 0, cs_rise = 0, cs_aligned = 0, tx_take = 0, tx_valid;
  logic [ADDR_W-1:0] qry_addr;
  logic prot_en = 0, status_ok = 1, cfg_wpen;
  logic [1:0] cfg_bp;
  int prot_lo = 0, prot_hi = 0;
  int checks = 0, errors = 0;
  logic [7:0] model [int];
  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wire arr_ok = !(prot_en && int'(qry_addr) >= prot_lo && int'(qry_addr) < prot_hi);

  eecmd_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(64), .WRITE_CYCLES(WCYC)) u_eecmd_engine (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .tx_take(tx_take),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .qry_addr(qry_addr),
    .qry_array_ok(arr_ok), .qry_status_ok(status_ok),
    .cfg_wpen(cfg_wpen), .cfg_bp(cfg_bp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each byte as the front end takes it
  always @(negedge clk) begin
    if (tx_take) begin
      if (sb_q.size() == 0) chk("R5 unexpected byte", {24'd0, tx_byte}, 32'hFFFF);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, {24'd0, tx_byte}, {24'd0, e.v});
      end
    end
  end

  task automatic idle(input int n); repeat (n) @(posedge clk); endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1 rx_byte = b; rx_valid = 1;
    @(posedge clk); #1 rx_valid = 0;
    idle(2);
  endtask

  task automatic cs_end(input logic aligned);
    @(posedge clk); #1 cs_rise = 1; cs_aligned = aligned;
    @(posedge clk); #1 cs_rise = 0; cs_aligned = 0;
    idle(2);
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rdsr(output logic [7:0] v);
    send(8'h05);
    wait_valid();
    v = tx_byte;
    cs_end(1);
  endtask

  task automatic cmd1(input logic [7:0] b); send(b); cs_end(1); endtask

  // last byte: 0 = separate aligned rise, 1 = rise with byte, 2 = misaligned rise
  task automatic wr(input logic [15:0] a, input logic [7:0] d[$], input int mode);
    send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < d.size() - 1; i++) send(d[i]);
    if (mode == 1) begin
      @(posedge clk); #1 rx_byte = d[d.size()-1]; rx_valid = 1; cs_rise = 1; cs_aligned = 1;
      @(posedge clk); #1 rx_valid = 0; cs_rise = 0; cs_aligned = 0;
      idle(2);
    end else begin
      send(d[d.size()-1]);
      cs_end(mode == 0);
    end
  endtask

  task automatic model_wr(input int a, input logic [7:0] d[$]);
    int base, ad;
    base = (a % DEPTH) & ~63;
    for (int i = 0; i < d.size(); i++) begin
      ad = base + (((a % 64) + i) % 64);
      if (!(prot_en && ad >= prot_lo && ad < prot_hi)) model[ad] = d[i];
    end
  endtask

  task automatic rd_chk(input logic [15:0] a, input int n, input string tag);
    send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = model[(int'(a) + i) % DEPTH];
      e.tag = tag;
      sb_q.push_back(e);
      wait_valid();
      @(posedge clk); #1 tx_take = 1;
      @(posedge clk); #1 tx_take = 0;
      @(posedge clk); @(negedge clk);
      chk("R12 next byte ready", {31'd0, tx_valid}, 32'd1);
    end
    cs_end(1);
    chk("R5 all bytes seen", sb_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] s;
    idle(3); #1 rst = 0; idle(2);
    @(negedge clk);
    chk("R3 reset tx_valid", {31'd0, tx_valid}, 0);
    rdsr(s); chk("R3 R4 reset status", {24'd0, s}, 32'h00);
    cmd1(8'h0E); rdsr(s); chk("R1 R3 set-enable with bit3", {24'd0, s}, 32'h02);
    cmd1(8'h04); rdsr(s); chk("R3 clear-enable", {24'd0, s}, 32'h00);

    // R13: last byte arrives with the aligned rise; bit15 ignored (R5)
    cmd1(8'h06);
    wr(16'h8040, '{8'h11, 8'h22, 8'h33, 8'h44}, 1);
    model_wr(16'h0040, '{8'h11, 8'h22, 8'h33, 8'h44});
    rdsr(s); chk("R4 R9 busy status", {24'd0, s}, 32'hFF);
    cmd1(8'h06); idle(100);
    rdsr(s); chk("R9 still busy", {24'd0, s}, 32'hFF);
    idle(WCYC);
    rdsr(s); chk("R3 R9 enable cleared, set ignored while busy", {24'd0, s}, 32'h00);
    rd_chk(16'hF840, 4, "R13 R5 page readback");

    // R6 page wrap
    cmd1(8'h06);
    wr(16'h007E, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 0);
    model_wr(16'h007E, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
    idle(WCYC + 10);
    rd_chk(16'h0040, 4, "R6 wrapped head");
    rd_chk(16'h007E, 2, "R6 page tail");

    // R7 write without enable
    wr(16'h0042, '{8'h55}, 0);
    rdsr(s); chk("R7 no busy without enable", {24'd0, s}, 32'h00);
    rd_chk(16'h0042, 1, "R7 data unchanged");

    // R8 misaligned rise
    cmd1(8'h06);
    wr(16'h0043, '{8'h66}, 2);
    rdsr(s); chk("R8 misaligned keeps enable, not busy", {24'd0, s}, 32'h02);
    rd_chk(16'h0043, 1, "R8 data unchanged");
    cmd1(8'h04);

    // R10 per-byte protection
    cmd1(8'h06); wr(16'h0100, '{8'h01, 8'h02, 8'h03, 8'h04}, 0);
    model_wr(16'h0100, '{8'h01, 8'h02, 8'h03, 8'h04}); idle(WCYC + 10);
    prot_en = 1; prot_lo = 'h102; prot_hi = 'h104;
    cmd1(8'h06); wr(16'h0100, '{8'hB0, 8'hB1, 8'hB2, 8'hB3}, 0);
    model_wr(16'h0100, '{8'hB0, 8'hB1, 8'hB2, 8'hB3}); idle(WCYC + 10);
    prot_en = 0;
    rd_chk(16'h0100, 4, "R10 protected bytes dropped");

    // R5 wrap from top address to zero
    cmd1(8'h06); wr(16'h07FE, '{8'hC1, 8'hC2}, 0);
    model_wr(16'h07FE, '{8'hC1, 8'hC2}); idle(WCYC + 10);
    cmd1(8'h06); wr(16'h0000, '{8'hD1, 8'hD2}, 0);
    model_wr(16'h0000, '{8'hD1, 8'hD2}); idle(WCYC + 10);
    rd_chk(16'h07FE, 4, "R5 read wraps to zero");

    // R11 status write
    cmd1(8'h06); send(8'h01); send(8'h8C); cs_end(1);
    rdsr(s); chk("R11 busy after status write", {24'd0, s}, 32'hFF);
    idle(WCYC + 10);
    rdsr(s); chk("R11 status stored", {24'd0, s}, 32'h8C);
    chk("R11 cfg outputs", {29'd0, cfg_wpen, cfg_bp}, 32'h7);
    status_ok = 0;
    cmd1(8'h06); send(8'h01); send(8'h00); cs_end(1);
    rdsr(s); chk("R11 refused status write", {24'd0, s}, 32'h8E);
    status_ok = 1;
    cmd1(8'h04);

    // R2 unknown opcodes swallow the rest of the transaction
    send(8'h16); send(8'h06);
    @(negedge clk); chk("R2 output quiet", {31'd0, tx_valid}, 0);
    cs_end(1);
    send(8'h0F); send(8'h06); cs_end(1);
    rdsr(s); chk("R1 R2 enable untouched", {24'd0, s}, 32'h8C);

    // R9 array read refused during busy
    cmd1(8'h06); wr(16'h0200, '{8'h5A}, 0); model_wr(16'h0200, '{8'h5A});
    send(8'h03); send(8'h02); send(8'h00);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_valid) seen++; end
      chk("R9 read ignored while busy", seen, 0);
    end
    cs_end(1);
    idle(WCYC + 10);
    rd_chk(16'h0200, 1, "R9 write landed");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule